// File: doc/BRIEF.md
# Four-Channel DMA Byte-Port Register Front End

This block is the host-facing register file of a four-channel DMA controller. The host reaches it over an 8-bit port bus that has a 4-bit port number, a write strobe and a read strobe. Each channel has one port for its memory offset and one for its transfer count. Both are 16-bit quantities that move as two byte transfers. A single pointer, shared by every channel, decides whether the next transfer carries the low or the high byte. Four more ports hold the single-channel mask, the per-channel mode, the pointer clear and a command byte.

The outputs go to the channel counters and to the request arbiter. They are the base offset and base count of each channel, a one-cycle load strobe for each of them, the decoded mode fields and the mask bits. The current offset and count come back from the counters and are read out through the same low-then-high byte sequence. The byte pointer is a two-state machine. In `PTR_LO` the next channel access carries the low byte; the `TAKE_LOW` transition goes to `PTR_HI`. In `PTR_HI` the access carries the high byte; the `TAKE_HIGH` transition goes back to `PTR_LO`. A write to the clear port, the `FLIP_CLEAR` transition, forces `PTR_LO` from either state.

Top module: `dma_port_frontend`

## Requirements
- R1: After reset, all four mask bits are 1, every mode field and the command byte are 0, no load strobe is active, and the byte pointer is in `PTR_LO`.
- R2: Channel n's offset port is port 2n. A low-byte write followed by a high-byte write sets `base_addr_o[16n+15:16n]` to {high,low}. In the cycle after the high-byte write, `addr_load_o[n]` is 1 for exactly one cycle. It is the only offset strobe set, and a low-byte write raises no strobe.
- R3: Channel n's count port is port 2n+1. The count is assembled the same way into `base_cnt_o[16n+15:16n]`, with a one-cycle `cnt_load_o[n]` strobe after the high byte.
- R4: A read of port 2n or 2n+1 returns the low byte of `cur_addr_i` or `cur_cnt_i` for channel n while the pointer is in `PTR_LO`, and the high byte while it is in `PTR_HI`.
- R5: Any read or write of ports 0 to 7 flips the shared pointer. A low byte sent to one channel port therefore makes the next byte to any other channel port a high byte.
- R6: Any write to port 0xC puts the pointer in `PTR_LO`, whatever the data byte.
- R7: A write to port 0xA changes only the mask bit of the channel in data bits 1:0, setting it to data bit 2. Bits 7:3 have no effect.
- R8: A write to port 0xB sets the mode of the channel in bits 1:0. Bits 3:2 drive `xfer_o` (00 verify, 01 write, 10 read), bit 4 drives `auto_init_o`, bit 5 drives `addr_dec_o`, and bits 7:6 drive `mode_kind_o` (00 demand, 01 single, 10 block, 11 cascade). Byte 0x45 gives channel 1 write/single, and 0x49 gives channel 1 read/single.
- R9: A write to port 0x8 stores the whole byte on `cmd_o`.
- R10: A read of any port other than 0 to 7 returns 0 and leaves the pointer unchanged. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Port number |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data byte |
| cur_addr_i | input | 64 | Current offset of each channel, 16 bits per channel |
| cur_cnt_i | input | 64 | Current count of each channel, 16 bits per channel |
| base_addr_o | output | 64 | Base offset of each channel |
| base_cnt_o | output | 64 | Base count of each channel |
| addr_load_o | output | 4 | Offset load strobe for each channel |
| cnt_load_o | output | 4 | Count load strobe for each channel |
| mask_o | output | 4 | Mask bit for each channel |
| xfer_o | output | 8 | Transfer type, 2 bits per channel |
| auto_init_o | output | 4 | Auto-init flag for each channel |
| addr_dec_o | output | 4 | Address-decrement flag for each channel |
| mode_kind_o | output | 8 | Service mode, 2 bits per channel |
| cmd_o | output | 8 | Command byte |

## Verification
The 16-bit assembly is exercised in three ways. Paired writes to a single port confirm byte order and strobe placement. Low and high bytes split across different channel ports show that the pointer is shared rather than kept per port. A clear written between the two bytes shows that the pointer returns to the low byte. Mask writes with the upper bits set separate a decode that uses only bits 2:0 from one that loads the whole byte. Mode bytes 0x45 and 0x49 pin down the field positions. Random sequences that mix reads, writes and mask and mode updates catch any case where one channel's state is disturbed by traffic meant for another.

// File: rtl/dma_fe_pkg.sv
`timescale 1ns/1ps
package dma_fe_pkg;
    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_t;

    localparam logic [3:0] PORT_CMD  = 4'h8;
    localparam logic [3:0] PORT_MASK = 4'hA;
    localparam logic [3:0] PORT_MODE = 4'hB;
    localparam logic [3:0] PORT_CLR  = 4'hC;

    typedef struct packed {
        logic [1:0] kind;
        logic       dec;
        logic       auto_init;
        logic [1:0] xfer;
    } mode_t;
endpackage

// File: rtl/dma_byte_ptr.sv
`timescale 1ns/1ps
module dma_byte_ptr
    import dma_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_access,
    input  logic clr_ptr,
    output logic ptr_hi
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_ptr) begin
            state_d = PTR_LO;                 // FLIP_CLEAR
        end else begin
            unique case (state_q)
                PTR_LO: if (chan_access) state_d = PTR_HI;  // TAKE_LOW
                PTR_HI: if (chan_access) state_d = PTR_LO;  // TAKE_HIGH
                default: state_d = PTR_LO;
            endcase
        end
    end

    always_comb begin
        ptr_hi = (state_q == PTR_HI);
    end
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs #(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_addr,
    input  logic             ld_cnt,
    input  logic [VAL_W-1:0] value,
    output logic [VAL_W-1:0] base_addr,
    output logic [VAL_W-1:0] base_cnt,
    output logic             addr_load,
    output logic             cnt_load
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            addr_load <= 1'b0;
            cnt_load  <= 1'b0;
        end else begin
            addr_load <= ld_addr;
            cnt_load  <= ld_cnt;
            if (ld_addr) base_addr <= value;
            if (ld_cnt)  base_cnt  <= value;
        end
    end
endmodule

// File: rtl/dma_ctrl_regs.sv
`timescale 1ns/1ps
module dma_ctrl_regs
    import dma_fe_pkg::*;
#(
    parameter int CH_NUM = 4,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_mask,
    input  logic                wr_mode,
    input  logic                wr_cmd,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [CH_NUM-1:0]   mask,
    output mode_t [CH_NUM-1:0]  mode,
    output logic [BYTE_W-1:0]   cmd
);
    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
        logic hit;
        assign hit = (int'(wdata[1:0]) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[g] <= 1'b1;
                mode[g] <= '0;
            end else begin
                if (wr_mask && hit) mask[g] <= wdata[2];
                if (wr_mode && hit) mode[g] <= mode_t'(wdata[7:2]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cmd <= '0;
        else if (wr_cmd) cmd <= wdata;
    end
endmodule

// File: rtl/dma_port_frontend.sv
`timescale 1ns/1ps
module dma_port_frontend
    import dma_fe_pkg::*;
#(
    parameter int CH_NUM = 4,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 4,
    localparam int VAL_W = 2 * BYTE_W,
    localparam int SEL_W = $clog2(CH_NUM)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BYTE_W-1:0]       bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [BYTE_W-1:0]       bus_rdata,
    input  logic [CH_NUM*VAL_W-1:0] cur_addr_i,
    input  logic [CH_NUM*VAL_W-1:0] cur_cnt_i,
    output logic [CH_NUM*VAL_W-1:0] base_addr_o,
    output logic [CH_NUM*VAL_W-1:0] base_cnt_o,
    output logic [CH_NUM-1:0]       addr_load_o,
    output logic [CH_NUM-1:0]       cnt_load_o,
    output logic [CH_NUM-1:0]       mask_o,
    output logic [2*CH_NUM-1:0]     xfer_o,
    output logic [CH_NUM-1:0]       auto_init_o,
    output logic [CH_NUM-1:0]       addr_dec_o,
    output logic [2*CH_NUM-1:0]     mode_kind_o,
    output logic [BYTE_W-1:0]       cmd_o
);
    logic              chan_hit;
    logic [SEL_W-1:0]  sel;
    logic              is_cnt;
    logic              chan_access;
    logic              clr_ptr;
    logic              ptr_hi;
    logic [BYTE_W-1:0] lo_hold;
    logic [VAL_W-1:0]  wr_value;
    logic [VAL_W-1:0]  rd_value;
    logic [BYTE_W-1:0] rd_byte;
    mode_t [CH_NUM-1:0] mode;

    assign chan_hit    = (bus_addr < ADDR_W'(2 * CH_NUM));
    assign sel         = bus_addr[SEL_W:1];
    assign is_cnt      = bus_addr[0];
    assign chan_access = (bus_wr || bus_rd) && chan_hit;
    assign clr_ptr     = bus_wr && (bus_addr == ADDR_W'(PORT_CLR));
    assign wr_value    = {bus_wdata, lo_hold};

    dma_byte_ptr u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_access (chan_access),
        .clr_ptr     (clr_ptr),
        .ptr_hi      (ptr_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                             lo_hold <= '0;
        else if (bus_wr && chan_hit && !ptr_hi) lo_hold <= bus_wdata;
    end

    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
        logic ld_a, ld_c;
        assign ld_a = bus_wr && chan_hit && ptr_hi && (int'(sel) == g) && !is_cnt;
        assign ld_c = bus_wr && chan_hit && ptr_hi && (int'(sel) == g) &&  is_cnt;

        dma_chan_regs #(.BYTE_W(BYTE_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_addr   (ld_a),
            .ld_cnt    (ld_c),
            .value     (wr_value),
            .base_addr (base_addr_o[g*VAL_W +: VAL_W]),
            .base_cnt  (base_cnt_o[g*VAL_W +: VAL_W]),
            .addr_load (addr_load_o[g]),
            .cnt_load  (cnt_load_o[g])
        );

        assign xfer_o[2*g +: 2]      = mode[g].xfer;
        assign auto_init_o[g]        = mode[g].auto_init;
        assign addr_dec_o[g]         = mode[g].dec;
        assign mode_kind_o[2*g +: 2] = mode[g].kind;
    end

    dma_ctrl_regs #(.CH_NUM(CH_NUM), .BYTE_W(BYTE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (bus_wr && (bus_addr == ADDR_W'(PORT_MASK))),
        .wr_mode (bus_wr && (bus_addr == ADDR_W'(PORT_MODE))),
        .wr_cmd  (bus_wr && (bus_addr == ADDR_W'(PORT_CMD))),
        .wdata   (bus_wdata),
        .mask    (mask_o),
        .mode    (mode),
        .cmd     (cmd_o)
    );

    always_comb begin
        rd_value = is_cnt ? cur_cnt_i[sel*VAL_W +: VAL_W]
                          : cur_addr_i[sel*VAL_W +: VAL_W];
        rd_byte  = '0;
        if (bus_rd && chan_hit)
            rd_byte = ptr_hi ? rd_value[VAL_W-1:BYTE_W] : rd_value[BYTE_W-1:0];
    end

    assign bus_rdata = rd_byte;
endmodule

// File: rtl/dma_port_frontend_chk.sv
`timescale 1ns/1ps
module dma_port_frontend_chk #(
    parameter int CH_NUM = 4,
    parameter int ADDR_W = 4,
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic                ptr_hi,
    input logic [CH_NUM-1:0]   addr_load_o,
    input logic [CH_NUM-1:0]   cnt_load_o,
    input logic [CH_NUM-1:0]   mask_o,
    input logic [2*CH_NUM-1:0] xfer_o,
    input logic [CH_NUM-1:0]   auto_init_o,
    input logic [CH_NUM-1:0]   addr_dec_o,
    input logic [2*CH_NUM-1:0] mode_kind_o,
    input logic [BYTE_W-1:0]   cmd_o
);
    logic hit;
    assign hit = (bus_addr < ADDR_W'(2 * CH_NUM));

    // R2
    addr_load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_load_o));
    // R2
    addr_load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_load_o) |-> $past(bus_wr && hit && !bus_addr[0] && ptr_hi));
    // R3
    cnt_load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_load_o));
    // R3
    cnt_load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cnt_load_o) |-> $past(bus_wr && hit && bus_addr[0] && ptr_hi));
    // R5
    ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && hit) |=> (ptr_hi != $past(ptr_hi)));
    // R6
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4'hC)) |=> !ptr_hi);
    // R7
    mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_o) |-> $past(bus_wr && bus_addr == ADDR_W'(4'hA)));
    // R7
    mask_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask_o ^ $past(mask_o)) <= 1);
    // R8
    mode_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({xfer_o, auto_init_o, addr_dec_o, mode_kind_o})
            |-> $past(bus_wr && bus_addr == ADDR_W'(4'hB)));
    // R9
    cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> $past(bus_wr && bus_addr == ADDR_W'(4'h8)));
endmodule

bind dma_port_frontend dma_port_frontend_chk #(
    .CH_NUM(CH_NUM), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .ptr_hi      (ptr_hi),
    .addr_load_o (addr_load_o),
    .cnt_load_o  (cnt_load_o),
    .mask_o      (mask_o),
    .xfer_o      (xfer_o),
    .auto_init_o (auto_init_o),
    .addr_dec_o  (addr_dec_o),
    .mode_kind_o (mode_kind_o),
    .cmd_o       (cmd_o)
);

// File: tb/dma_port_frontend_tb.sv
`timescale 1ns/1ps
module dma_port_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [63:0] cur_addr_i = '0;
    logic [63:0] cur_cnt_i = '0;
    logic [63:0] base_addr_o, base_cnt_o;
    logic [3:0]  addr_load_o, cnt_load_o, mask_o, auto_init_o, addr_dec_o;
    logic [7:0]  xfer_o, mode_kind_o, cmd_o;

    always #2 clk = ~clk;

    dma_port_frontend dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cur_addr_i(cur_addr_i), .cur_cnt_i(cur_cnt_i),
        .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
        .addr_load_o(addr_load_o), .cnt_load_o(cnt_load_o), .mask_o(mask_o),
        .xfer_o(xfer_o), .auto_init_o(auto_init_o), .addr_dec_o(addr_dec_o),
        .mode_kind_o(mode_kind_o), .cmd_o(cmd_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask;
    logic [7:0]  m_cmd;
    logic [7:0]  m_lo;
    logic        m_ptr;
    logic [3:0]  e_aload, e_cload;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pack16(input logic [15:0] v [4]);
        return {v[3], v[2], v[1], v[0]};
    endfunction

    function automatic logic [7:0] f_xfer();
        logic [7:0] r;
        for (int i = 0; i < 4; i++) r[2*i +: 2] = m_mode[i][1:0];
        return r;
    endfunction

    function automatic logic [7:0] f_kind();
        logic [7:0] r;
        for (int i = 0; i < 4; i++) r[2*i +: 2] = m_mode[i][5:4];
        return r;
    endfunction

    function automatic logic [3:0] f_bit(input int b);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = m_mode[i][b];
        return r;
    endfunction

    task automatic check_all(string tag);
        chk({tag, " R2 base_addr"}, base_addr_o, pack16(m_addr));
        chk({tag, " R3 base_cnt"}, base_cnt_o, pack16(m_cnt));
        chk({tag, " R2 addr_load"}, addr_load_o, e_aload);
        chk({tag, " R3 cnt_load"}, cnt_load_o, e_cload);
        chk({tag, " R7 mask"}, mask_o, m_mask);
        chk({tag, " R8 xfer"}, xfer_o, f_xfer());
        chk({tag, " R8 auto"}, auto_init_o, f_bit(2));
        chk({tag, " R8 dec"}, addr_dec_o, f_bit(3));
        chk({tag, " R8 kind"}, mode_kind_o, f_kind());
        chk({tag, " R9 cmd"}, cmd_o, m_cmd);
    endtask

    task automatic do_wr(string tag, logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        e_aload = '0; e_cload = '0;
        if (a < 4'd8) begin
            if (!m_ptr) m_lo = d;
            else if (a[0]) begin m_cnt[a[2:1]] = {d, m_lo};  e_cload[a[2:1]] = 1'b1; end
            else           begin m_addr[a[2:1]] = {d, m_lo}; e_aload[a[2:1]] = 1'b1; end
            m_ptr = ~m_ptr;
        end else if (a == 4'h8) m_cmd = d;
        else if (a == 4'hA) m_mask[d[1:0]] = d[2];
        else if (a == 4'hB) m_mode[d[1:0]] = d[7:2];
        else if (a == 4'hC) m_ptr = 1'b0;
        check_all(tag);
    endtask

    task automatic do_rd(string tag, logic [3:0] a);
        logic [15:0] v;
        logic [7:0]  e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v = a[0] ? cur_cnt_i[a[2:1]*16 +: 16] : cur_addr_i[a[2:1]*16 +: 16];
        e = (a < 4'd8) ? (m_ptr ? v[15:8] : v[7:0]) : 8'h00;
        chk({tag, (a < 4'd8) ? " R4 rdata" : " R10 rdata"}, bus_rdata, e);
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        chk({tag, " R10 idle rdata"}, bus_rdata, 8'h00);
        if (a < 4'd8) m_ptr = ~m_ptr;
        e_aload = '0; e_cload = '0;
    endtask

    task automatic wr16(string tag, logic [3:0] a, logic [15:0] v);
        do_wr(tag, a, v[7:0]);
        do_wr(tag, a, v[15:8]);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = '0; m_mode[i] = '0; end
        m_mask = 4'hF; m_cmd = '0; m_lo = '0; m_ptr = 1'b0;
        e_aload = '0; e_cload = '0;
        cur_addr_i = 64'h1A2B_3C4D_5E6F_7081;
        cur_cnt_i  = 64'h9192_A3A4_B5B6_C7C8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1 reset");

        // R2/R3 directed writes, first byte after reset is low (R1)
        wr16("R2 ch0", 4'h0, 16'hBEEF);
        wr16("R3 ch2", 4'h5, 16'h1234);
        wr16("R2 ch3", 4'h6, 16'hFFFF);
        wr16("R3 ch3 zero", 4'h7, 16'h0000);

        // R4 reads low then high
        do_rd("R4 ch1 addr lo", 4'h2);
        do_rd("R4 ch1 addr hi", 4'h2);
        do_rd("R4 ch3 cnt lo", 4'h7);
        do_rd("R4 ch3 cnt hi", 4'h7);

        // R5 shared pointer across ports
        do_wr("R5 lo to ch1 addr", 4'h2, 8'h55);
        do_wr("R5 hi to ch0 cnt", 4'h1, 8'hAA);
        do_rd("R5 read after write toggles", 4'h0);
        do_wr("R5 hi after read", 4'h4, 8'h77);

        // R6 clear between bytes
        do_wr("R6 lo", 4'h0, 8'h11);
        do_wr("R6 clear", 4'hC, 8'h5A);
        do_wr("R6 restart lo", 4'h0, 8'h22);
        do_wr("R6 hi", 4'h0, 8'h33);

        // R7 mask with junk upper bits
        do_wr("R7 unmask ch3 junk", 4'hA, 8'hFB);
        do_wr("R7 unmask ch1", 4'hA, 8'h01);
        do_wr("R7 mask ch1 junk", 4'hA, 8'hF5);
        do_wr("R7 unmask ch0", 4'hA, 8'h00);

        // R8 mode bytes
        do_wr("R8 0x45", 4'hB, 8'h45);
        chk("R8 ch1 write xfer", xfer_o[3:2], 2'b01);
        chk("R8 ch1 single", mode_kind_o[3:2], 2'b01);
        do_wr("R8 0x49", 4'hB, 8'h49);
        chk("R8 ch1 read xfer", xfer_o[3:2], 2'b10);
        do_wr("R8 ch2 all ones", 4'hB, 8'hFE);
        do_wr("R8 ch0 cascade dec", 4'hB, 8'hE0);

        // R9 command
        do_wr("R9 cmd", 4'h8, 8'hC4);

        // R10 non-channel reads leave pointer alone
        do_wr("R10 lo", 4'h3, 8'h9D);
        do_rd("R10 port9", 4'h9);
        do_rd("R10 portE", 4'hE);
        do_wr("R10 hi", 4'h3, 8'h4E);
        do_wr("R10 port9 write ignored", 4'h9, 8'hFF);
        do_wr("R10 portF write ignored", 4'hF, 8'hFF);

        // random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (k % 50 == 0) begin
                cur_addr_i = {$urandom, $urandom};
                cur_cnt_i  = {$urandom, $urandom};
            end
            case (op)
                0, 1, 2: wr16("rnd R2/R3 16", 4'($urandom_range(0, 7)), 16'($urandom));
                3:       do_wr("rnd R5 single", 4'($urandom_range(0, 7)), 8'($urandom));
                4:       do_rd("rnd R4 read", 4'($urandom_range(0, 15)));
                5:       do_wr("rnd R7 mask", 4'hA, 8'($urandom));
                6:       do_wr("rnd R8 mode", 4'hB, 8'($urandom));
                7:       do_wr("rnd R9 cmd", 4'h8, 8'($urandom));
                8:       do_wr("rnd R6 clr", 4'hC, 8'($urandom));
                default: do_wr("rnd R10 unused", 4'($urandom_range(13, 15)), 8'($urandom));
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule